// File: doc/BRIEF.md
# Selectable Periodic Interrupt Generator

This block drives an active-low interrupt line for a timekeeper. A stored 3-bit select code picks one of three behaviours. In off, the line stays high. In pulse style, the line carries a free-running square wave of 2 Hz or 1 Hz with 50% duty. In level style, the line falls on a chosen calendar event (every second, minute, hour or month) and stays low until software clears it. A status flag mirrors the line: it reads 1 whenever the line is driven low.

The block keeps its own sub-second phase counter. The divider steps it with `sub_tick`, which pulses 2^PHASE_BITS times per second. The pulse waveforms are taken from this counter, so the falling edge of the 1 Hz wave lines up with the seconds increment. The timekeeper counters supply one-cycle event strobes. Each strobe is raised in the cycle the counters reach the event: second 00 for the minute event, minute 00 and second 00 for the hour event, and 00:00:00 on day 01 for the month event. A write to the seconds counter resets the phase. The flag write port lets software release a level-style interrupt.

Top module: `periodic_irq_gen`

## Requirements
- R1: Synchronous reset clears the select code to off and the phase to 0. After reset `irq_n` is 1 and `flag` is 0, and a select write of code 2 then shows the wave starting at phase 0 (low).
- R2: Select codes 0 (off) and 7 (reserved) hold `irq_n` at 1 and `flag` at 0, whatever `sub_tick`, `sec_wr`, `ev_strobe` and flag writes do.
- R3: Code 2 (1 Hz): `irq_n` is low while the phase is in its lower half (0 and 1 with PHASE_BITS=2) and high in its upper half (2 and 3). It changes in the cycle after the `sub_tick` that moves the phase.
- R4: Code 1 (2 Hz): `irq_n` equals phase bit PHASE_BITS-2. It is low at phases 0 and 2 and high at phases 1 and 3.
- R5: Codes 3, 4, 5 and 6 latch the event strobe bits 0 (second), 1 (minute), 2 (hour) and 3 (month) respectively. `irq_n` goes low in the cycle after the strobe and stays low.
- R6: In level style, strobe bits other than the selected one, and `sub_tick`, leave `irq_n` unchanged.
- R7: `flag` is always the inverse of `irq_n`.
- R8: A flag write of 0 in level style releases `irq_n` high in the next cycle. A flag write of 1 has no effect in any style. A flag write of 0 in pulse style has no effect.
- R9: When the selected event strobe and a flag write of 0 arrive in the same cycle, the event wins and `irq_n` stays low.
- R10: `sec_wr` resets the phase to 0, so in pulse style `irq_n` is low in the next cycle. `sec_wr` takes priority over a coincident `sub_tick`.
- R11: A select write clears any pending level interrupt. The new code governs `irq_n` from the next cycle, and a strobe arriving in the same cycle as the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sub_tick | input | 1 | Sub-second strobe, 2^PHASE_BITS per second |
| sec_wr | input | 1 | Strobe: the seconds counter was written |
| ev_strobe | input | N_EV | Event strobes: bit0 second, bit1 minute, bit2 hour, bit3 month |
| sel_wr | input | 1 | Select code write strobe |
| sel_din | input | 3 | Select code to store |
| flag_wr | input | 1 | Flag write strobe |
| flag_din | input | 1 | Flag write data (only 0 acts) |
| irq_n | output | 1 | Interrupt line, active low |
| flag | output | 1 | Interrupt status, 1 while irq_n is low |

## Verification
The assertions take the input strobes to be single-cycle and synchronous to `clk`. They check each effect only in cycles where no select write competes, because a select write overrides the latch and the style. The event properties rely on the counters raising at most the strobes that belong to one instant. The stimulus follows these rules: it changes inputs only between edges, it holds every strobe for exactly one cycle, and it applies the deliberate collisions (an event together with a clear, a select write together with a strobe, `sec_wr` together with `sub_tick`) as separate cycles whose outcome the requirements define.

// File: rtl/pirq_pkg.sv
// Package: shared select codes and style classification for the periodic
// interrupt generator. Assumes a 3-bit select field.
package pirq_pkg;

    typedef enum logic [2:0] {
        SEL_OFF   = 3'd0,
        SEL_P2HZ  = 3'd1,
        SEL_P1HZ  = 3'd2,
        SEL_LSEC  = 3'd3,
        SEL_LMIN  = 3'd4,
        SEL_LHOUR = 3'd5,
        SEL_LMON  = 3'd6,
        SEL_RSVD  = 3'd7
    } sel_e;

    typedef enum logic [1:0] {
        STY_OFF   = 2'd0,
        STY_PULSE = 2'd1,
        STY_LEVEL = 2'd2
    } style_e;

    // Map a select code onto its output style.
    function automatic style_e style_of(sel_e s);
        case (s)
            SEL_P2HZ, SEL_P1HZ:                      return STY_PULSE;
            SEL_LSEC, SEL_LMIN, SEL_LHOUR, SEL_LMON: return STY_LEVEL;
            default:                                 return STY_OFF;
        endcase
    endfunction

endpackage

// File: rtl/pirq_phase.sv
// Sub-second phase counter.
// It advances on each sub_tick and wraps once per second. A seconds write
// clears it and takes priority over a tick in the same cycle. The two pulse
// waveforms are taken straight from its top bits.
// Assumes PHASE_BITS >= 2 and single-cycle strobes.
module pirq_phase #(
    parameter int PHASE_BITS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sub_tick,
    input  logic sec_wr,
    output logic wave_1hz,
    output logic wave_2hz
);
    localparam int MSB = PHASE_BITS - 1;

    logic [MSB:0] phase_q;

    // Phase register: clear on reset or seconds write, otherwise step on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)        phase_q <= '0;
        else if (sec_wr)   phase_q <= '0;
        else if (sub_tick) phase_q <= phase_q + 1'b1;
    end

    // Waveforms: low in the first half (or quarter pair) after each boundary.
    assign wave_1hz = phase_q[MSB];
    assign wave_2hz = phase_q[MSB-1];

endmodule

// File: rtl/pirq_level.sv
// Level-style interrupt latch.
// It sets on the selected event and clears on a software flag write of 0.
// A set beats a clear that arrives in the same cycle. The latch is forced
// clear while the style is not level, and on any select write.
// Assumes fire, clr and sel_wr are single-cycle strobes.
module pirq_level (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic fire,
    input  logic clr,
    input  logic sel_wr,
    output logic pending
);
    logic pend_q;

    // Pending latch with priority: reset, select write or disarm, then set,
    // then clear.
    always_ff @(posedge clk) begin
        if (!rst_n)               pend_q <= 1'b0;
        else if (sel_wr || !arm)  pend_q <= 1'b0;
        else if (fire)            pend_q <= 1'b1;
        else if (clr)             pend_q <= 1'b0;
    end

    assign pending = pend_q;

endmodule

// File: rtl/periodic_irq_gen.sv
// Selectable periodic interrupt generator (top).
// It holds the select code and picks an output style: off, a 2 Hz or 1 Hz
// square wave, or a latched level on a second, minute, hour or month event.
// It drives the active-low line and the status flag.
// Assumes the event strobes are one cycle wide and already placed at the
// event instant by the timekeeper counters.
module periodic_irq_gen
    import pirq_pkg::*;
#(
    parameter int PHASE_BITS = 2,
    parameter int N_EV       = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sub_tick,
    input  logic            sec_wr,
    input  logic [N_EV-1:0] ev_strobe,
    input  logic            sel_wr,
    input  logic [2:0]      sel_din,
    input  logic            flag_wr,
    input  logic            flag_din,
    output logic            irq_n,
    output logic            flag
);
    sel_e            sel_q;
    style_e          style;
    logic            wave_1hz;
    logic            wave_2hz;
    logic            wave_sel;
    logic [N_EV-1:0] hit;
    logic            fire;
    logic            pending;

    // Select register: cleared to off by reset, loaded by a select write.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= SEL_OFF;
        else if (sel_wr) sel_q <= sel_e'(sel_din);
    end

    // Style decode of the stored code.
    assign style = style_of(sel_q);

    pirq_phase #(.PHASE_BITS(PHASE_BITS)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .sub_tick (sub_tick),
        .sec_wr   (sec_wr),
        .wave_1hz (wave_1hz),
        .wave_2hz (wave_2hz)
    );

    // Event match: strobe i belongs to level code SEL_LSEC + i.
    for (genvar i = 0; i < N_EV; i++) begin : g_hit
        localparam logic [2:0] CODE = 3'(3 + i);
        assign hit[i] = ev_strobe[i] && (sel_q == sel_e'(CODE));
    end

    assign fire = |hit;

    pirq_level u_level (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (style == STY_LEVEL),
        .fire    (fire),
        .clr     (flag_wr && !flag_din),
        .sel_wr  (sel_wr),
        .pending (pending)
    );

    // Pulse waveform choice between the two rates.
    assign wave_sel = (sel_q == SEL_P2HZ) ? wave_2hz : wave_1hz;

    // Line driver: high when off, the wave in pulse style, the latch in
    // level style.
    always_comb begin
        case (style)
            STY_PULSE: irq_n = wave_sel;
            STY_LEVEL: irq_n = !pending;
            default:   irq_n = 1'b1;
        endcase
    end

    // Status flag: reports an asserted interrupt in each style.
    always_comb begin
        case (style)
            STY_PULSE: flag = !wave_sel;
            STY_LEVEL: flag = pending;
            default:   flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/periodic_irq_gen_chk.sv
// Checker for periodic_irq_gen, attached with bind.
// It watches the ports and the stored select code. Assumes single-cycle strobes.
module periodic_irq_gen_chk
    import pirq_pkg::*;
#(
    parameter int N_EV = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sub_tick,
    input logic            sec_wr,
    input logic [N_EV-1:0] ev_strobe,
    input logic            sel_wr,
    input logic [2:0]      sel_din,
    input logic            flag_wr,
    input logic            flag_din,
    input logic [2:0]      sel_q,
    input logic            irq_n,
    input logic            flag
);
    logic is_lvl;
    logic is_pul;
    logic din_lvl;
    logic sel_hit;

    // Helper decodes of the stored and incoming select codes.
    always_comb begin
        is_lvl  = (style_of(sel_e'(sel_q)) == STY_LEVEL);
        is_pul  = (style_of(sel_e'(sel_q)) == STY_PULSE);
        din_lvl = (style_of(sel_e'(sel_din)) == STY_LEVEL);
        sel_hit = 1'b0;
        for (int i = 0; i < N_EV; i++)
            if (ev_strobe[i] && (sel_q == 3'(3 + i))) sel_hit = 1'b1;
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (irq_n && !flag));

    assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == 3'd0 || sel_q == 3'd7) |-> (irq_n && !flag));

    assert_wave_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pul && !sub_tick && !sec_wr && !sel_wr) |=> $stable(irq_n));

    assert_event_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_lvl && sel_hit && !sel_wr) |=> !irq_n);

    assert_flag_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flag == !irq_n);

    assert_one_noeffect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_lvl && !irq_n && flag_wr && flag_din && !sel_wr) |=> !irq_n);

    assert_clear_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_lvl && flag_wr && !flag_din && !sel_hit && !sel_wr) |=> irq_n);

    assert_event_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_lvl && flag_wr && !flag_din && sel_hit && !sel_wr) |=> !irq_n);

    assert_secwr_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pul && sec_wr && !sel_wr) |=> !irq_n);

    assert_selwr_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && din_lvl) |=> irq_n);

endmodule

bind periodic_irq_gen periodic_irq_gen_chk #(.N_EV(N_EV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sub_tick  (sub_tick),
    .sec_wr    (sec_wr),
    .ev_strobe (ev_strobe),
    .sel_wr    (sel_wr),
    .sel_din   (sel_din),
    .flag_wr   (flag_wr),
    .flag_din  (flag_din),
    .sel_q     (sel_q),
    .irq_n     (irq_n),
    .flag      (flag)
);

// File: tb/tb_periodic_irq_gen.sv
module tb_periodic_irq_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sub_tick = 1'b0;
    logic       sec_wr = 1'b0;
    logic [3:0] ev_strobe = 4'h0;
    logic       sel_wr = 1'b0;
    logic [2:0] sel_din = 3'd0;
    logic       flag_wr = 1'b0;
    logic       flag_din = 1'b0;
    logic       irq_n;
    logic       flag;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    periodic_irq_gen #(.PHASE_BITS(2), .N_EV(4)) dut (
        .clk (clk), .rst_n (rst_n), .sub_tick (sub_tick), .sec_wr (sec_wr),
        .ev_strobe (ev_strobe), .sel_wr (sel_wr), .sel_din (sel_din),
        .flag_wr (flag_wr), .flag_din (flag_din), .irq_n (irq_n), .flag (flag)
    );

    typedef struct packed {
        logic       tk;
        logic       sw;
        logic [3:0] ev;
        logic       swr;
        logic [2:0] sd;
        logic       fw;
        logic       fd;
        logic       ei;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 36;
    // Fields: tick, sec_wr, events, sel_wr, sel_din, flag_wr, flag_din,
    // expected irq_n, requirement number.
    localparam vec_t VT [NV] = '{
        '{1'b0,1'b0,4'h0,1'b1,3'd2,1'b0,1'b0,1'b0,4'd3},  // R3 1 Hz, phase 0
        '{1'b1,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,1'b0,4'd3},  // R3 phase 1
        '{1'b1,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,1'b1,4'd3},  // R3 phase 2
        '{1'b0,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,1'b1,4'd3},  // R3 hold
        '{1'b1,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,1'b1,4'd3},  // R3 phase 3
        '{1'b1,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,1'b0,4'd3},  // R3 wrap
        '{1'b0,1'b0,4'h0,1'b0,3'd0,1'b1,1'b0,1'b0,4'd8},  // R8 clear in pulse
        '{1'b1,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,1'b0,4'd3},  // R3 phase 1
        '{1'b1,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,1'b1,4'd3},  // R3 phase 2
        '{1'b1,1'b1,4'h0,1'b0,3'd0,1'b0,1'b0,1'b0,4'd10}, // R10 sec write wins
        '{1'b1,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,1'b0,4'd10}, // R10 restart phase 1
        '{1'b0,1'b0,4'h0,1'b1,3'd1,1'b0,1'b0,1'b1,4'd4},  // R4 2 Hz, phase 1
        '{1'b1,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,1'b0,4'd4},  // R4 phase 2
        '{1'b1,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,1'b1,4'd4},  // R4 phase 3
        '{1'b1,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,1'b0,4'd4},  // R4 phase 0
        '{1'b0,1'b0,4'h0,1'b1,3'd3,1'b0,1'b0,1'b1,4'd11}, // R11 to second event
        '{1'b0,1'b0,4'h2,1'b0,3'd0,1'b0,1'b0,1'b1,4'd6},  // R6 minute ignored
        '{1'b1,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,1'b1,4'd6},  // R6 tick ignored
        '{1'b0,1'b0,4'h1,1'b0,3'd0,1'b0,1'b0,1'b0,4'd5},  // R5 second event
        '{1'b0,1'b0,4'h0,1'b0,3'd0,1'b0,1'b0,1'b0,4'd5},  // R5 stays low
        '{1'b0,1'b0,4'h0,1'b0,3'd0,1'b1,1'b1,1'b0,4'd8},  // R8 write 1 ignored
        '{1'b0,1'b0,4'h0,1'b0,3'd0,1'b1,1'b0,1'b1,4'd8},  // R8 write 0 releases
        '{1'b0,1'b0,4'h1,1'b0,3'd0,1'b1,1'b0,1'b0,4'd9},  // R9 event beats clear
        '{1'b0,1'b0,4'h0,1'b0,3'd0,1'b1,1'b0,1'b1,4'd8},  // R8 release
        '{1'b0,1'b0,4'h0,1'b1,3'd4,1'b0,1'b0,1'b1,4'd11}, // R11 to minute event
        '{1'b0,1'b0,4'h1,1'b0,3'd0,1'b0,1'b0,1'b1,4'd6},  // R6 second ignored
        '{1'b0,1'b0,4'h2,1'b0,3'd0,1'b0,1'b0,1'b0,4'd5},  // R5 minute event
        '{1'b0,1'b0,4'h0,1'b1,3'd5,1'b0,1'b0,1'b1,4'd11}, // R11 write clears
        '{1'b0,1'b0,4'h4,1'b0,3'd0,1'b0,1'b0,1'b0,4'd5},  // R5 hour event
        '{1'b0,1'b0,4'h8,1'b1,3'd6,1'b0,1'b0,1'b1,4'd11}, // R11 strobe dropped
        '{1'b0,1'b0,4'h8,1'b0,3'd0,1'b0,1'b0,1'b0,4'd5},  // R5 month event
        '{1'b0,1'b0,4'h0,1'b1,3'd0,1'b0,1'b0,1'b1,4'd2},  // R2 off
        '{1'b1,1'b0,4'hF,1'b0,3'd0,1'b0,1'b0,1'b1,4'd2},  // R2 off ignores all
        '{1'b0,1'b0,4'h0,1'b1,3'd7,1'b0,1'b0,1'b1,4'd2},  // R2 reserved
        '{1'b1,1'b1,4'hF,1'b0,3'd0,1'b0,1'b0,1'b1,4'd2},  // R2 reserved ignores
        '{1'b0,1'b0,4'h0,1'b0,3'd0,1'b1,1'b0,1'b1,4'd2}   // R2 flag write
    };

    task automatic check(input string req, input logic got, input logic exp, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, got, exp, $time);
        end
    endtask

    // Checks both outputs against an expected line level (R7: flag is its inverse).
    task automatic check_out(input string req, input logic exp_irq);
        check(req, irq_n, exp_irq, "irq_n");
        check({req, "/R7"}, flag, !exp_irq, "flag");
    endtask

    // One cycle: drive at the falling edge, let a rising edge pass, return at
    // the next falling edge.
    task automatic run(input vec_t v);
        sub_tick = v.tk; sec_wr = v.sw; ev_strobe = v.ev;
        sel_wr = v.swr; sel_din = v.sd; flag_wr = v.fw; flag_din = v.fd;
        @(posedge clk);
        @(negedge clk);
        sub_tick = 1'b0; sec_wr = 1'b0; ev_strobe = 4'h0;
        sel_wr = 1'b0; sel_din = 3'd0; flag_wr = 1'b0; flag_din = 1'b0;
    endtask

    function automatic vec_t mk(logic tk, logic [3:0] ev, logic swr, logic [2:0] sd);
        vec_t v = '0;
        v.tk = tk; v.ev = ev; v.swr = swr; v.sd = sd;
        return v;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1", 1'b1);  // R1 reset state

        for (int i = 0; i < NV; i++) begin
            run(VT[i]);
            check_out($sformatf("R%0d row%0d", VT[i].rq, i), VT[i].ei);
        end

        // R1: reset while a level interrupt is pending.
        run(mk(1'b0, 4'h0, 1'b1, 3'd3));
        run(mk(1'b0, 4'h1, 1'b0, 3'd0));
        check_out("R5 pre-reset", 1'b0);
        run(mk(1'b1, 4'h0, 1'b0, 3'd0));
        rst_n = 1'b0;
        run(mk(1'b0, 4'h0, 1'b0, 3'd0));
        run(mk(1'b0, 4'h0, 1'b0, 3'd0));
        rst_n = 1'b1;
        check_out("R1 after reset", 1'b1);
        run(mk(1'b1, 4'hF, 1'b0, 3'd0));
        check_out("R1 select off", 1'b1);
        // Phase was cleared by reset; the tick above moved it to 1.
        run(mk(1'b0, 4'h0, 1'b1, 3'd2));
        check_out("R1 phase 1 low", 1'b0);
        run(mk(1'b1, 4'h0, 1'b0, 3'd0));
        check_out("R1 phase 2 high", 1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule